// File: doc/BRIEF.md
# Single-Line 1-Wire Bus Master

This block runs the two timed transactions that a host needs on an open-drain 1-Wire line. The first is the bus reset with presence detection. The master pulls the line low, lets it go, and looks for a device answering with a low pulse. The second is the byte exchange. Eight bit slots each send one bit and capture the line level at the same time. Bits go out least significant first, and each captured bit enters at the top of a shift register. After the eighth slot the returned byte therefore holds the bus bits in their natural order.

A host reads a byte by sending 0xFF and keeping the reply. It writes a byte by sending it and ignoring the reply. A clock divider makes a one-microsecond enable, and a phase counter runs on that enable, so every phase length is an exact whole number of system clocks. The line leaves the block as an output enable, which pulls low while it is high. The level on the line comes back in as a separate input.

Top module: `owire_master`

## Requirements
- R1: The cycle after `start_reset` is accepted, `bus_oe` goes high and stays high for exactly 480 µs, which is 480·CLK_PER_US clocks.
- R2: The line is then released for 64 µs. At the end of that window `bus_in` is sampled, and `presence` becomes 1 if the sample is low and 0 if it is high.
- R3: After the sample the line stays released for a further 416 µs. Then `busy` falls and `done` is high for exactly one clock. A reset transaction therefore keeps `busy` high for 960 µs.
- R4: Each of the eight bit slots of a touch starts with `bus_oe` high for 6 µs.
- R5: For a slot bit of 1, `bus_oe` is low from 6 µs until the slot ends. For a slot bit of 0, `bus_oe` stays high up to 66 µs. Every slot then has 2 µs of recovery with `bus_oe` low, so a slot lasts 68 µs.
- R6: `bus_in` is sampled 15 µs after the start of each slot. Bit i of `tx_byte` (bit 0 first) is sent in slot i. The sample of slot i appears as bit i of `rx_byte` when the touch completes, because each sample enters at bit 7 and the register shifts right.
- R7: When the host sends 0xFF, `rx_byte` equals the byte the device drives. When the host sends any other byte, `rx_byte` equals the bitwise AND of the sent byte and the device's byte.
- R8: `busy` is high from the clock after acceptance until the transaction completes. Any `start_reset` or `start_touch` seen while `busy` is high has no effect.
- R9: If `start_reset` and `start_touch` are both high while idle, the reset transaction runs.
- R10: While idle, `bus_oe` and `done` are low. `presence` and `rx_byte` keep their last values until the next transaction of the same kind completes.
- R11: During and after `rst_n` low: `busy`, `done`, `bus_oe`, `presence` and `rx_byte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_reset | input | 1 | Request a reset/presence transaction |
| start_touch | input | 1 | Request an eight-slot byte exchange |
| tx_byte | input | 8 | Byte sent by a touch, bit 0 first |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock pulse when a transaction ends |
| presence | output | 1 | 1 when a device answered the last reset |
| rx_byte | output | 8 | Line samples of the last touch |
| bus_oe | output | 1 | High pulls the line low |
| bus_in | input | 1 | Sampled level of the line |

## Verification
The first timed effect of a command shows up one clock after the edge that accepts it. From then on, every `bus_oe` level, `busy` and `done` has a fixed clock index: each phase ends after exactly its length in µs times CLK_PER_US clocks. `done` falls one clock after the last recovery or wait. The bench turns each accepted command into a per-clock queue of expected `bus_oe`/`busy`/`done` values. It checks one entry at every falling edge, starting with the cycle after acceptance. It reads `presence` and `rx_byte` only after that queue has drained. A behavioural device reacts to the line, so the sampling instants at 64 µs and at 15 µs are tested through the returned values.

// File: rtl/owire_pkg.sv
package owire_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_RST_REST,
        ST_SLOT_LOW,
        ST_SLOT_BIT,
        ST_SLOT_HOLD,
        ST_SLOT_REC
    } owire_state_e;

endpackage

// File: rtl/owire_tick.sv
module owire_tick #(
    parameter int CLK_PER_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_s;

    tick_s tk_d, tk_q;

    always_comb begin
        tk_d = tk_q;
        if (clear || tk_q.cnt == LAST) begin
            tk_d.cnt = '0;
        end else begin
            tk_d.cnt = tk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tk_q <= '0;
        end else begin
            tk_q <= tk_d;
        end
    end

    assign tick = (tk_q.cnt == LAST) && !clear;

endmodule

// File: rtl/owire_seq.sv
module owire_seq
    import owire_pkg::*;
#(
    parameter int T_RST_LOW  = 480,
    parameter int T_PRES     = 64,
    parameter int T_RST_REST = 416,
    parameter int T_SLOT_LOW = 6,
    parameter int T_SAMPLE   = 15,
    parameter int T_HOLD     = 51,
    parameter int T_REC      = 2,
    parameter int NBITS      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_reset,
    input  logic             start_touch,
    input  logic [NBITS-1:0] tx_byte,
    input  logic             bus_in,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic             presence,
    output logic [NBITS-1:0] rx_byte,
    output logic             bus_oe
);
    localparam int T_BIT = T_SAMPLE - T_SLOT_LOW;
    localparam int MAX_A = (T_RST_LOW > T_RST_REST) ? T_RST_LOW : T_RST_REST;
    localparam int MAX_B = (T_PRES > T_HOLD) ? T_PRES : T_HOLD;
    localparam int TMAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int PW    = $clog2(TMAX + 1);
    localparam int BW    = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

    typedef struct packed {
        owire_state_e     st;
        logic [PW-1:0]    pcnt;
        logic [BW-1:0]    bitn;
        logic [NBITS-1:0] sh;
        logic             cur;
        logic             pres;
        logic [NBITS-1:0] rx;
        logic             done;
    } seq_s;

    seq_s sq_d, sq_q;
    logic phase_end;

    function automatic logic [PW-1:0] span_of(owire_state_e s);
        case (s)
            ST_RST_LOW:   span_of = PW'(T_RST_LOW - 1);
            ST_RST_WAIT:  span_of = PW'(T_PRES - 1);
            ST_RST_REST:  span_of = PW'(T_RST_REST - 1);
            ST_SLOT_LOW:  span_of = PW'(T_SLOT_LOW - 1);
            ST_SLOT_BIT:  span_of = PW'(T_BIT - 1);
            ST_SLOT_HOLD: span_of = PW'(T_HOLD - 1);
            ST_SLOT_REC:  span_of = PW'(T_REC - 1);
            default:      span_of = '0;
        endcase
    endfunction

    assign busy      = (sq_q.st != ST_IDLE);
    assign accept    = !busy && (start_reset || start_touch);
    assign phase_end = tick && (sq_q.pcnt == span_of(sq_q.st));

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        if (sq_q.st == ST_IDLE) begin
            sq_d.pcnt = '0;
            if (start_reset) begin
                sq_d.st = ST_RST_LOW;
            end else if (start_touch) begin
                sq_d.st   = ST_SLOT_LOW;
                sq_d.sh   = tx_byte;
                sq_d.bitn = '0;
            end
        end else if (tick) begin
            if (!phase_end) begin
                sq_d.pcnt = sq_q.pcnt + 1'b1;
            end else begin
                sq_d.pcnt = '0;
                case (sq_q.st)
                    ST_RST_LOW:  sq_d.st = ST_RST_WAIT;
                    ST_RST_WAIT: begin
                        sq_d.st   = ST_RST_REST;
                        sq_d.pres = !bus_in;
                    end
                    ST_RST_REST: begin
                        sq_d.st   = ST_IDLE;
                        sq_d.done = 1'b1;
                    end
                    ST_SLOT_LOW: begin
                        sq_d.st  = ST_SLOT_BIT;
                        sq_d.cur = sq_q.sh[0];
                    end
                    ST_SLOT_BIT: begin
                        sq_d.st = ST_SLOT_HOLD;
                        sq_d.sh = {bus_in, sq_q.sh[NBITS-1:1]};
                    end
                    ST_SLOT_HOLD: sq_d.st = ST_SLOT_REC;
                    ST_SLOT_REC: begin
                        if (sq_q.bitn == LAST_BIT) begin
                            sq_d.st   = ST_IDLE;
                            sq_d.done = 1'b1;
                            sq_d.rx   = sq_q.sh;
                        end else begin
                            sq_d.st   = ST_SLOT_LOW;
                            sq_d.bitn = sq_q.bitn + 1'b1;
                        end
                    end
                    default: sq_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q    <= '0;
            sq_q.st <= ST_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    always_comb begin
        case (sq_q.st)
            ST_RST_LOW, ST_SLOT_LOW:   bus_oe = 1'b1;
            ST_SLOT_BIT, ST_SLOT_HOLD: bus_oe = !sq_q.cur;
            default:                   bus_oe = 1'b0;
        endcase
    end

    assign done     = sq_q.done;
    assign presence = sq_q.pres;
    assign rx_byte  = sq_q.rx;

endmodule

// File: rtl/owire_master.sv
module owire_master #(
    parameter int CLK_PER_US = 200,
    parameter int T_RST_LOW  = 480,
    parameter int T_PRES     = 64,
    parameter int T_RST_REST = 416,
    parameter int T_SLOT_LOW = 6,
    parameter int T_SAMPLE   = 15,
    parameter int T_HOLD     = 51,
    parameter int T_REC      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_reset,
    input  logic       start_touch,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic [7:0] rx_byte,
    output logic       bus_oe,
    input  logic       bus_in
);
    logic us_tick;
    logic cmd_accept;

    owire_tick #(
        .CLK_PER_US(CLK_PER_US)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cmd_accept),
        .tick  (us_tick)
    );

    owire_seq #(
        .T_RST_LOW  (T_RST_LOW),
        .T_PRES     (T_PRES),
        .T_RST_REST (T_RST_REST),
        .T_SLOT_LOW (T_SLOT_LOW),
        .T_SAMPLE   (T_SAMPLE),
        .T_HOLD     (T_HOLD),
        .T_REC      (T_REC),
        .NBITS      (8)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (us_tick),
        .start_reset (start_reset),
        .start_touch (start_touch),
        .tx_byte     (tx_byte),
        .bus_in      (bus_in),
        .accept      (cmd_accept),
        .busy        (busy),
        .done        (done),
        .presence    (presence),
        .rx_byte     (rx_byte),
        .bus_oe      (bus_oe)
    );

endmodule

// File: rtl/owire_master_chk.sv
module owire_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_reset,
    input logic       start_touch,
    input logic       busy,
    input logic       done,
    input logic       presence,
    input logic [7:0] rx_byte,
    input logic       bus_oe
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_oe); // R10
    AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (start_reset || start_touch)) |=> busy); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |=> ($stable(rx_byte) && $stable(presence))); // R10
endmodule

bind owire_master owire_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_reset (start_reset),
    .start_touch (start_touch),
    .busy        (busy),
    .done        (done),
    .presence    (presence),
    .rx_byte     (rx_byte),
    .bus_oe      (bus_oe)
);

// File: tb/owire_master_bench.sv
`timescale 1ns/1ps
module owire_master_bench;
    localparam int CPU = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_reset = 1'b0;
    logic       start_touch = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       busy, done, presence, bus_oe, bus_in;
    logic [7:0] rx_byte;

    int checks = 0;
    int errors = 0;

    // device model state
    logic       dev_present = 1'b1;
    logic [7:0] dev_byte = 8'hFF;
    logic       prev_oe = 1'b0;
    int         cyc = 0;
    int         low_cnt = 0;
    int         pull_from = 0;
    int         pull_until = 0;
    int         dev_idx = 0;
    logic       dev_pull;

    logic [2:0] ref_q[$];   // {oe, busy, done} per clock

    always #2.5 clk = ~clk;

    owire_master #(.CLK_PER_US(CPU)) u_owire_master (
        .clk(clk), .rst_n(rst_n), .start_reset(start_reset),
        .start_touch(start_touch), .tx_byte(tx_byte), .busy(busy),
        .done(done), .presence(presence), .rx_byte(rx_byte),
        .bus_oe(bus_oe), .bus_in(bus_in)
    );

    assign dev_pull = (cyc >= pull_from) && (cyc < pull_until);
    assign bus_in   = !(bus_oe || dev_pull);

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        prev_oe <= bus_oe;
        if (bus_oe) low_cnt <= prev_oe ? low_cnt + 1 : 1;
        if (bus_oe && !prev_oe) begin
            if (!dev_byte[dev_idx]) begin
                pull_from  <= cyc;
                pull_until <= cyc + 30 * CPU;
            end
            dev_idx <= (dev_idx + 1) % 8;
        end
        if (!bus_oe && prev_oe && low_cnt >= 400 * CPU) begin
            dev_idx <= 0;
            if (dev_present) begin
                pull_from  <= cyc + 20 * CPU;
                pull_until <= cyc + 140 * CPU;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference comparison
    int shown = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [2:0] e;
            e = (ref_q.size() > 0) ? ref_q.pop_front() : 3'b000;
            checks++;
            if ({bus_oe, busy, done} !== e) begin
                errors++;
                if (shown < 20) begin
                    shown++;
                    $display("FAIL R1 R3 R4 R5 R8 R10 clk %0d {oe,busy,done} actual=%b expected=%b",
                             cyc, {bus_oe, busy, done}, e);
                end
            end
        end
    end

    task automatic push_phase(input int us, input logic oe);
        for (int i = 0; i < us * CPU; i++) ref_q.push_back({oe, 2'b10});
    endtask

    task automatic expect_reset();
        push_phase(480, 1'b1);   // R1
        push_phase(64, 1'b0);    // R2
        push_phase(416, 1'b0);   // R3
        ref_q.push_back(3'b001);
    endtask

    task automatic expect_touch(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            push_phase(6, 1'b1);       // R4
            push_phase(9, !b[i]);      // R5
            push_phase(51, !b[i]);     // R5
            push_phase(2, 1'b0);       // R5
        end
        ref_q.push_back(3'b001);
    endtask

    task automatic pulse(input logic r, input logic t, input logic [7:0] b);
        @(posedge clk); #1;
        start_reset = r; start_touch = t; tx_byte = b;
        @(posedge clk); #1;
        start_reset = 1'b0; start_touch = 1'b0;
    endtask

    task automatic drain();
        while (ref_q.size() > 0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk("R11 busy", busy, 0);
        chk("R11 oe", bus_oe, 0);
        chk("R11 presence", presence, 0);
        chk("R11 rx_byte", rx_byte, 0);
        chk("R11 done", done, 0);
        rst_n = 1'b1;

        // reset with device present
        dev_present = 1'b1;
        pulse(1'b1, 1'b0, 8'h00); expect_reset(); drain();
        chk("R2 presence present", presence, 1);

        // reset with nothing on the line
        dev_present = 1'b0;
        pulse(1'b1, 1'b0, 8'h00); expect_reset(); drain();
        chk("R2 presence absent", presence, 0);
        dev_present = 1'b1;

        // read: send ones
        dev_byte = 8'hA5;
        pulse(1'b0, 1'b1, 8'hFF); expect_touch(8'hFF); drain();
        chk("R6 R7 read A5", rx_byte, 8'hA5);

        // write: device all ones
        dev_byte = 8'hFF;
        pulse(1'b0, 1'b1, 8'h3C); expect_touch(8'h3C); drain();
        chk("R7 write 3C", rx_byte, 8'h3C);

        // mixed
        dev_byte = 8'h96;
        pulse(1'b0, 1'b1, 8'h0F); expect_touch(8'h0F); drain();
        chk("R7 and 0F/96", rx_byte, 8'h06);

        // commands while busy are ignored
        dev_byte = 8'h5A;
        pulse(1'b0, 1'b1, 8'hFF); expect_touch(8'hFF);
        repeat (300) @(posedge clk);
        pulse(1'b1, 1'b0, 8'h00);
        repeat (500) @(posedge clk);
        pulse(1'b0, 1'b1, 8'h00);
        drain();
        chk("R8 ignored cmds", rx_byte, 8'h5A);

        // both requests together: reset wins
        dev_present = 1'b0;
        pulse(1'b1, 1'b1, 8'h00); expect_reset(); drain();
        chk("R9 reset priority rx kept", rx_byte, 8'h5A);
        chk("R9 reset priority presence", presence, 0);

        // idle hold
        repeat (200) @(posedge clk);
        #1;
        chk("R10 rx hold", rx_byte, 8'h5A);
        chk("R10 presence hold", presence, 0);
        chk("R10 idle oe", bus_oe, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule